// File: doc/BRIEF.md
# Peripheral Clock-Enable and Reset Sequencer

This block powers a single peripheral up or down in a safe order. The peripheral has a bit in a clock-stop bank and may also have a bit in a reset bank. A one-cycle enable request first holds the peripheral in reset. It then starts the peripheral's clock and waits a settle interval, counted in reference clock cycles, before it releases reset. A disable request only stops the clock. The block does not keep the two banks. It sends single-cycle set or clear commands to them and reads back the two bits it controls.

Each command is issued only while an arbitration grant is high. A busy output tells the arbiter that a sequence is in flight. A clock bit may use inverted polarity, so that setting the bit starts the clock. A reset index with its top bit set means the peripheral has no reset line. The is-enabled output combines the clock bit and the reset bit. A peripheral that is held in reset never counts as enabled.

Top module: `periph_seq`

## Requirements
- R1: `is_en` is high only when the clock bit shows running and, if a reset index is configured, `rst_bit` is 0. Running means `clk_bit`=0 when `inv_pol`=0, and `clk_bit`=1 when `inv_pol`=1.
- R2: If `is_en` is already high when an enable request is accepted, no command is issued and `done` pulses in the cycle after acceptance.
- R3: An enable of a peripheral that has a reset index issues exactly three commands, in this order: set the reset bit, start the clock, clear the reset bit.
- R4: The reset-clear command comes exactly SETTLE_CYCLES+1 cycles after the clock-start command, provided the grant stays high.
- R5: A reset index whose top bit (`rst_idx[IDX_W]`) is 1 means there is no reset. The enable then issues only the clock-start command.
- R6: A disable request issues exactly one command, a clock stop, and leaves the reset bit unchanged.
- R7: With `inv_pol`=0, a clock start clears the bit and a clock stop sets it. With `inv_pol`=1, both are the other way round.
- R8: `busy` rises in the cycle after a request is accepted and stays high until the final command. Requests that arrive while `busy` or `done` is high are ignored.
- R9: Each command is a one-cycle `cmd_vld` pulse with `cmd_clk` (1 = clock bank, 0 = reset bank), `cmd_set` (1 = set, 0 = clear) and `cmd_idx`. A command is issued only while `gnt` is high; while `gnt` is low, the sequence stalls.
- R10: `done` is a one-cycle pulse in the cycle after the final command, and `busy` is low while `done` is high.
- R11: After reset, `busy`, `done` and `cmd_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Enable request pulse (wins over disable) |
| dis_req | input | 1 | Disable request pulse |
| clk_idx | input | IDX_W | Clock-bank bit index |
| rst_idx | input | IDX_W+1 | Reset-bank bit index; top bit set means none |
| inv_pol | input | 1 | Clock bit polarity: 1 means set starts the clock |
| gnt | input | 1 | Arbitration grant for the register banks |
| clk_bit | input | 1 | Current value of the addressed clock bit |
| rst_bit | input | 1 | Current value of the addressed reset bit |
| busy | output | 1 | Sequence in flight |
| done | output | 1 | Completion pulse |
| cmd_vld | output | 1 | Command strobe |
| cmd_clk | output | 1 | Command target: 1 clock bank, 0 reset bank |
| cmd_set | output | 1 | 1 set, 0 clear |
| cmd_idx | output | IDX_W | Command bit index |
| is_en | output | 1 | Peripheral enabled status |

## Verification
The bench builds the block with IDX_W=6, which gives a 64-bit bank on each side and lets bit 63 serve as an edge index. It sets SETTLE_CYCLES=20. That value is short enough for every enable ordering, and both polarities, to finish within a few dozen cycles. It is still long enough to check the exact distance between the clock start and the reset release, and to send stray requests into the middle of the wait.

// File: rtl/periph_seq.sv
module periph_seq #(
  parameter int IDX_W = 6,
  parameter int SETTLE_CYCLES = 250000,
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             dis_req,
  input  logic [IDX_W-1:0] clk_idx,
  input  logic [IDX_W:0]   rst_idx,
  input  logic             inv_pol,
  input  logic             gnt,
  input  logic             clk_bit,
  input  logic             rst_bit,
  output logic             busy,
  output logic             done,
  output logic             cmd_vld,
  output logic             cmd_clk,
  output logic             cmd_set,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             is_en
);
  typedef enum logic [2:0] {S_IDLE, S_ARST, S_CLKON, S_WAIT, S_DRST, S_CLKOFF, S_DONE} st_t;
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYCLES);

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] c_idx, r_idx;
  logic             inv_q, nores_q;

  assign is_en = (inv_pol ? clk_bit : ~clk_bit) & (rst_idx[IDX_W] | ~rst_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      c_idx   <= '0;
      r_idx   <= '0;
      inv_q   <= 1'b0;
      nores_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (en_req || dis_req) begin
          c_idx   <= clk_idx;
          r_idx   <= rst_idx[IDX_W-1:0];
          inv_q   <= inv_pol;
          nores_q <= rst_idx[IDX_W];
          if (en_req) st <= is_en ? S_DONE : (rst_idx[IDX_W] ? S_CLKON : S_ARST);
          else        st <= S_CLKOFF;
        end
        S_ARST:  if (gnt) st <= S_CLKON;
        S_CLKON: if (gnt) begin
          st  <= nores_q ? S_DONE : S_WAIT;
          cnt <= SETTLE_LD;
        end
        S_WAIT: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= S_DRST;
        end
        S_DRST, S_CLKOFF: if (gnt) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_clk = (st == S_CLKON) | (st == S_CLKOFF);
  assign cmd_vld = gnt & (cmd_clk | (st == S_ARST) | (st == S_DRST));
  assign cmd_set = (st == S_ARST) | ((st == S_CLKON) & inv_q) | ((st == S_CLKOFF) & ~inv_q);
  assign cmd_idx = cmd_clk ? c_idx : r_idx;
  assign busy    = (st != S_IDLE) & (st != S_DONE);
  assign done    = (st == S_DONE);
endmodule

// File: rtl/periph_seq_chk.sv
module periph_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en_req,
  input logic dis_req,
  input logic gnt,
  input logic busy,
  input logic done,
  input logic cmd_vld
);
  // R9
  cmd_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_vld |-> gnt);
  // R9
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_vld |-> busy);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en_req || dis_req));
endmodule

bind periph_seq periph_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
  .gnt(gnt), .busy(busy), .done(done), .cmd_vld(cmd_vld)
);

// File: tb/periph_seq_test.sv
`timescale 1ns/1ps
module periph_seq_test;
  localparam int S = 20;
  logic clk = 0, rst_n = 0, en_req = 0, dis_req = 0, inv_pol = 0, gnt = 1;
  logic [5:0] clk_idx = 0;
  logic [6:0] rst_idx = 0;
  logic busy, done, cmd_vld, cmd_clk, cmd_set, is_en;
  logic [5:0] cmd_idx;
  logic [63:0] cbank = '1, rbank = '0;

  periph_seq #(.IDX_W(6), .SETTLE_CYCLES(S)) uut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .clk_idx(clk_idx), .rst_idx(rst_idx), .inv_pol(inv_pol), .gnt(gnt),
    .clk_bit(cbank[clk_idx]), .rst_bit(rbank[rst_idx[5:0]]),
    .busy(busy), .done(done), .cmd_vld(cmd_vld), .cmd_clk(cmd_clk),
    .cmd_set(cmd_set), .cmd_idx(cmd_idx), .is_en(is_en));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, n_cmd = 0, done_cnt = 0, done_cyc = 0, req_cyc = 0;
  logic [7:0] log_c [0:127];
  int log_cyc [0:127];
  logic pl_go = 0, pl_cb = 0, pl_rb = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (pl_go) begin
      cbank[clk_idx] = pl_cb;
      rbank[rst_idx[5:0]] = pl_rb;
    end
    if (cmd_vld) begin
      log_c[n_cmd & 127] = {cmd_clk, cmd_set, cmd_idx};
      log_cyc[n_cmd & 127] = cyc;
      n_cmd = n_cmd + 1;
      if (cmd_clk) cbank[cmd_idx] = cmd_set;
      else         rbank[cmd_idx] = cmd_set;
    end
    if (done) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
    end
    if ((en_req || dis_req) && !busy && !done) req_cyc = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic preload(input logic [5:0] c, input logic [6:0] r, input logic inv,
                         input logic cb, input logic rb);
    @(posedge clk); #2;
    clk_idx = c; rst_idx = r; inv_pol = inv; pl_cb = cb; pl_rb = rb; pl_go = 1;
    @(posedge clk); #2;
    pl_go = 0;
  endtask

  task automatic pulse(input logic op);
    @(posedge clk); #2;
    en_req = op; dis_req = !op;
    @(posedge clk); #2;
    en_req = 0; dis_req = 0;
  endtask

  task automatic wait_done(input int d0, input string req);
    int t = 0;
    while (done_cnt == d0 && t < 500) begin
      @(posedge clk); t++;
    end
    if (t >= 500) chk(0, req, 0, 1);
    repeat (2) @(posedge clk);
  endtask

  // fields: cidx[21:16] ridx[15:9] inv[8] cb[7] rb[6] op[5] exp_en[4]
  localparam logic [21:0] VEC [0:8] = '{
    {6'd5,  7'd7,    1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0},
    {6'd14, 7'd14,   1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0},
    {6'd3,  7'h7F,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0},
    {6'd5,  7'd7,    1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0},
    {6'd5,  7'd7,    1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0},
    {6'd5,  7'd7,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},
    {6'd14, 7'd14,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},
    {6'd63, 7'd0,    1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0},
    {6'd2,  7'h7F,   1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0}
  };

  initial begin
    #1_200_000;
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    chk(busy == 0 && done == 0 && cmd_vld == 0, "R11", int'({busy, done, cmd_vld}), 0);
    rst_n = 1;

    for (int v = 0; v < 9; v++) begin
      logic [5:0] c; logic [6:0] r; logic inv, cb, rb, op, een, already;
      logic [7:0] ex [0:2];
      int ne, base, d0;
      string tag;
      {c, r, inv, cb, rb, op, een} = VEC[v][21:4];
      already = (inv ? cb : !cb) && (r[6] || !rb);
      if (!op) begin
        ne = 1; ex[0] = {1'b1, !inv, c}; tag = "R6";
      end else if (already) begin
        ne = 0; tag = "R2";
      end else if (r[6]) begin
        ne = 1; ex[0] = {1'b1, inv, c}; tag = "R5";
      end else begin
        ne = 3; ex[0] = {1'b0, 1'b1, r[5:0]}; ex[1] = {1'b1, inv, c};
        ex[2] = {1'b0, 1'b0, r[5:0]}; tag = "R3";
      end
      preload(c, r, inv, cb, rb);
      base = n_cmd; d0 = done_cnt;
      pulse(op);
      wait_done(d0, tag);
      chk(n_cmd - base == ne, tag, n_cmd - base, ne);
      for (int k = 0; k < ne; k++)
        chk(log_c[(base + k) & 127] == ex[k], "R7 R9 command", int'(log_c[(base + k) & 127]), int'(ex[k]));
      if (ne == 3)
        chk(log_cyc[(base + 2) & 127] - log_cyc[(base + 1) & 127] == S + 1, "R4",
            log_cyc[(base + 2) & 127] - log_cyc[(base + 1) & 127], S + 1);
      if (ne > 0)
        chk(done_cyc == log_cyc[(base + ne - 1) & 127] + 1, "R10", done_cyc, log_cyc[(base + ne - 1) & 127] + 1);
      else
        chk(done_cyc == req_cyc + 1, "R2 done", done_cyc, req_cyc + 1);
      chk(done_cnt == d0 + 1, "R10 single", done_cnt - d0, 1);
      chk(is_en == een, "R1", int'(is_en), int'(een));
      if (!op) chk(rbank[r[5:0]] == rb, "R6 reset bit", int'(rbank[r[5:0]]), int'(rb));
    end

    // R1 direct: running clock held in reset counts disabled
    preload(6'd20, 7'd21, 1'b0, 1'b0, 1'b1);
    #1 chk(is_en == 0, "R1 in reset", int'(is_en), 0);
    preload(6'd20, 7'd21, 1'b0, 1'b0, 1'b0);
    #1 chk(is_en == 1, "R1 out of reset", int'(is_en), 1);
    preload(6'd20, 7'h7F, 1'b0, 1'b0, 1'b1);
    #1 chk(is_en == 1, "R1 no reset index", int'(is_en), 1);

    // R8 requests during busy are ignored
    begin
      int base, d0;
      preload(6'd9, 7'd10, 1'b0, 1'b1, 1'b0);
      base = n_cmd; d0 = done_cnt;
      pulse(1'b1);
      repeat (5) @(posedge clk);
      #2 chk(busy == 1, "R8 busy", int'(busy), 1);
      pulse(1'b0);
      pulse(1'b1);
      wait_done(d0, "R8");
      repeat (10) @(posedge clk);
      chk(n_cmd - base == 3, "R8 ignored", n_cmd - base, 3);
      chk(done_cnt - d0 == 1, "R8 one done", done_cnt - d0, 1);
      chk(is_en == 1, "R8 enabled", int'(is_en), 1);
    end

    // R9 grant stall
    begin
      int base, d0;
      preload(6'd11, 7'h7F, 1'b0, 1'b1, 1'b0);
      gnt = 0;
      base = n_cmd; d0 = done_cnt;
      pulse(1'b1);
      repeat (6) @(posedge clk);
      #2;
      chk(busy == 1, "R9 stall busy", int'(busy), 1);
      chk(n_cmd == base, "R9 stall no cmd", n_cmd - base, 0);
      gnt = 1;
      wait_done(d0, "R9");
      chk(n_cmd - base == 1, "R9 resume", n_cmd - base, 1);
      chk(is_en == 1, "R9 enabled", int'(is_en), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule